// File: doc/BRIEF.md
# RAM Bank Size Probe Engine

After each start pulse this engine finds out how much RAM sits in each of two banks. It does not walk the whole array. It writes a short block of words at the base of a bank. It then reads back at the offsets where that block would show up again if the bank were smaller than the largest size the memory controller was told to assume. The first offset that returns the whole block gives the bank's size. Bank 1 is handled the same way, one fixed step higher in the address space.

The engine is the only master on a simple word-wide memory port. It holds each request until the memory acknowledges it. At the end it loads a 4-bit bank configuration register and presents the top-of-RAM byte address. The configuration register can also be written directly while the engine is idle.

Top module: `ram_size_probe`

## Requirements
- R1: After reset, `cfg_q` is 0000, `done` and `error` are low, `mem_req` is low and `top_of_ram` is 0.
- R2: A start pulse seen while idle loads `cfg_q` with 1010 (largest size in both banks) and clears `done`. `cfg_q` holds that value for as long as any memory request is outstanding.
- R3: Probing a bank first writes 256 words to byte offsets 0x000 to 0x1FE from the bank base, in ascending order. The word at index i carries i XOR 0xA55A for bank 0 and i XOR 0x5AA5 for bank 1. All addresses are even.
- R4: The engine reads the block back in this order: at offset 0x200 (a match gives code 00, 128 KB), then at 0x400 (code 01, 512 KB), then at 0x000 (code 10, 2 MB). A mismatch on any word ends that read window at once, and the next candidate starts from word 0.
- R5: If all three candidates fail for bank 0, the engine finishes with `error` high, `cfg_q` left at 1010 and `top_of_ram` 0. Bank 1 is never accessed in that case.
- R6: Bank 1 uses the same sequence with every address raised by 0x200000. If all three candidates fail, bank 1 is taken as absent: its code is 00, it adds nothing to the total, and no error is raised.
- R7: On success `cfg_q` = {bank-0 code, bank-1 code}, with bank 0 in bits [3:2] and bank 1 in bits [1:0]. `top_of_ram` is the sum of the sizes found (0x20000, 0x80000 or 0x200000 per bank). Code 11 is never produced.
- R8: `done` stays high until the next start pulse, and its first cycle comes with `mem_req` low. `error` is high only while `done` is high.
- R9: A request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle in which `mem_ack` is high. The transfer, and the sampling of `mem_rdata`, happen in that cycle.
- R10: `cfg_we` loads `cfg_wdata` into `cfg_q` while the engine is idle. It has no effect while probing is under way, and start takes priority in the same cycle.
- R11: A start pulse during probing is ignored: no restart, no extra accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe run (single-cycle pulse) |
| cfg_we | input | 1 | Direct write strobe for the configuration register |
| cfg_wdata | input | 4 | Value for a direct configuration write |
| cfg_q | output | 4 | Bank configuration register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer completes this cycle |
| done | output | 1 | Probe finished, held until next start |
| error | output | 1 | Bank 0 could not be sized |
| top_of_ram | output | ADDR_W | Total RAM in bytes |

## Verification
The bench models each bank as a small array that folds addresses at 0x200, at 0x400 or not at all, and can also model an absent bank or a single broken word. For each configuration it counts reads, writes and bank-1 accesses. A design that does not abort on the first bad word, or that tries the candidates in the wrong order, gives the wrong read count even when the final code happens to be right. An engine that reads stale contents as valid, or that flags a missing bank 1 as a fault, ends with the wrong code or a spurious error. A broken word in bank 0 must end in an error with no access to bank 1. Start and direct register writes are also issued during a probe: a restart would double the write count, and an accepted direct write would show in `cfg_q` while probing.

// File: rtl/ram_size_probe.sv
module ram_size_probe #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WIN_WORDS = 256,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 24'h200000,
  parameter logic [ADDR_W-1:0] FOLD_SMALL = 24'h000200,
  parameter logic [ADDR_W-1:0] FOLD_MID = 24'h000400,
  parameter logic [DATA_W-1:0] PAT0 = 16'hA55A,
  parameter logic [DATA_W-1:0] PAT1 = 16'h5AA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] top_of_ram
);

  localparam int IDX_W = $clog2(WIN_WORDS);
  localparam logic [ADDR_W-1:0] SZ_SMALL = ADDR_W'(32'h0002_0000);
  localparam logic [ADDR_W-1:0] SZ_MID   = ADDR_W'(32'h0008_0000);
  localparam logic [ADDR_W-1:0] SZ_BIG   = ADDR_W'(32'h0020_0000);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_READ} state_t;

  state_t            st;
  logic              bank;
  logic [1:0]        cand;
  logic [1:0]        code0;
  logic [IDX_W-1:0]  idx;
  logic [3:0]        cfg_r;
  logic              done_r, err_r;
  logic [ADDR_W-1:0] top_r;
  logic [ADDR_W-1:0] off;

  function automatic logic [ADDR_W-1:0] size_of(input logic [1:0] c);
    case (c)
      2'b00:   return SZ_SMALL;
      2'b01:   return SZ_MID;
      default: return SZ_BIG;
    endcase
  endfunction

  always_comb begin
    off = '0;
    if (st == S_READ) begin
      case (cand)
        2'd0:    off = FOLD_SMALL;
        2'd1:    off = FOLD_MID;
        default: off = '0;
      endcase
    end
  end

  wire last_word = (idx == IDX_W'(WIN_WORDS - 1));
  wire word_hit  = (mem_rdata == mem_wdata);

  assign mem_req    = (st != S_IDLE);
  assign mem_we     = (st == S_WRITE);
  assign mem_addr   = (bank ? BANK1_BASE : '0) + off + ADDR_W'({idx, 1'b0});
  assign mem_wdata  = DATA_W'(idx) ^ (bank ? PAT1 : PAT0);
  assign cfg_q      = cfg_r;
  assign done       = done_r;
  assign error      = done_r & err_r;
  assign top_of_ram = top_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      bank   <= 1'b0;
      cand   <= 2'd0;
      code0  <= 2'd0;
      idx    <= '0;
      cfg_r  <= 4'b0000;
      done_r <= 1'b0;
      err_r  <= 1'b0;
      top_r  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            cfg_r  <= 4'b1010;
            done_r <= 1'b0;
            err_r  <= 1'b0;
            top_r  <= '0;
            bank   <= 1'b0;
            cand   <= 2'd0;
            idx    <= '0;
            st     <= S_WRITE;
          end else if (cfg_we) begin
            cfg_r <= cfg_wdata;
          end
        end
        S_WRITE: begin
          if (mem_ack) begin
            if (last_word) begin
              idx  <= '0;
              cand <= 2'd0;
              st   <= S_READ;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_READ: begin
          if (mem_ack) begin
            if (!word_hit) begin
              idx <= '0;
              if (cand == 2'd2) begin
                if (!bank) begin
                  err_r  <= 1'b1;
                  done_r <= 1'b1;
                  st     <= S_IDLE;
                end else begin
                  cfg_r  <= {code0, 2'b00};
                  top_r  <= size_of(code0);
                  done_r <= 1'b1;
                  st     <= S_IDLE;
                end
              end else begin
                cand <= cand + 2'd1;
              end
            end else if (last_word) begin
              idx <= '0;
              if (!bank) begin
                code0 <= cand;
                bank  <= 1'b1;
                st    <= S_WRITE;
              end else begin
                cfg_r  <= {code0, cand};
                top_r  <= size_of(code0) + size_of(cand);
                done_r <= 1'b1;
                st     <= S_IDLE;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  p_cfg_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cfg_q == 4'b1010);

  p_err_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> cfg_q == 4'b1010 && top_of_ram == '0);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !mem_req);

  p_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !error |-> cfg_q[3:2] != 2'b11 && cfg_q[1:0] != 2'b11);

endmodule

// File: tb/sim_ram_size_probe.sv
module sim_ram_size_probe;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = 4'h0;
  logic [3:0]  cfg_q;
  logic        mem_req, mem_we, mem_ack;
  logic [23:0] mem_addr, top_of_ram;
  logic [15:0] mem_wdata, mem_rdata;
  logic        done, error;

  int n_chk = 0, n_fail = 0;
  int sz0 = 0, sz1 = 0, bad0 = -1;
  int n_rd = 0, n_wr = 0, n_hi = 0, wr_bad = 0;
  logic clr = 1'b0;
  logic ack_q = 1'b0;
  logic [15:0] m0 [0:767];
  logic [15:0] m1 [0:767];

  always #(CLK_P/2) clk = ~clk;

  ram_size_probe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .done(done), .error(error), .top_of_ram(top_of_ram));

  assign mem_ack = ack_q;

  // sz: 0 folds at 0x200, 1 folds at 0x400, 2 no fold, 3 absent
  function automatic int word_of(input logic [23:0] a, input int sz);
    int o;
    o = int'(a[10:0]);
    if (sz == 0) o = o % 512;
    else if (sz == 1) o = o % 1024;
    return (o >> 1) % 768;
  endfunction

  always_comb begin
    if (!mem_addr[21]) begin
      if (sz0 == 3) mem_rdata = 16'hFFFF;
      else if (word_of(mem_addr, sz0) == bad0) mem_rdata = 16'h0000;
      else mem_rdata = m0[word_of(mem_addr, sz0)];
    end else begin
      if (sz1 == 3) mem_rdata = 16'hFFFF;
      else mem_rdata = m1[word_of(mem_addr, sz1)];
    end
  end

  always @(posedge clk) begin
    ack_q <= rst_n && mem_req && !ack_q;
    if (clr) begin
      for (int i = 0; i < 768; i++) begin m0[i] = 16'h0000; m1[i] = 16'h0000; end
      n_rd = 0; n_wr = 0; n_hi = 0; wr_bad = 0;
    end else if (mem_req && ack_q) begin
      if (mem_addr[21]) n_hi++;
      if (mem_we) begin
        n_wr++;
        if (mem_addr[20:9] != 0 || mem_addr[0] ||
            mem_wdata != ({8'h00, mem_addr[8:1]} ^ (mem_addr[21] ? 16'h5AA5 : 16'hA55A)))
          wr_bad++;
        if (!mem_addr[21]) begin if (sz0 != 3) m0[word_of(mem_addr, sz0)] = mem_wdata; end
        else begin if (sz1 != 3) m1[word_of(mem_addr, sz1)] = mem_wdata; end
      end else n_rd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem(input int s0, input int s1, input int b);
    @(negedge clk);
    sz0 = s0; sz1 = s1; bad0 = b;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
  endtask

  task automatic run_probe(input int s0, input int s1, input int b, input logic [3:0] ecfg,
                           input logic [23:0] etop, input logic eerr, input int erd,
                           input int ewr, input int ehi, input string tag);
    clear_mem(s0, s1, b);
    pulse_start();
    chk(done == 1'b0 && cfg_q == 4'hA, {tag, " R2 start"}, {done, cfg_q}, 5'h0A);
    wait_done();
    chk(done == 1'b1, {tag, " R8 done"}, done, 1);
    chk(error == eerr, {tag, " R5 R6 error"}, error, eerr);
    chk(cfg_q == ecfg, {tag, " R7 cfg"}, cfg_q, ecfg);
    chk(top_of_ram == etop, {tag, " R7 top"}, top_of_ram, etop);
    chk(n_rd == erd, {tag, " R4 read count"}, n_rd, erd);
    chk(n_wr == ewr && wr_bad == 0, {tag, " R3 writes"}, n_wr, ewr);
    chk(n_hi == ehi, {tag, " R6 bank1 accesses"}, n_hi, ehi);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cfg_q == 4'h0 && !done && !error && !mem_req && top_of_ram == 0,
        "R1 reset state", {cfg_q, done, error, mem_req}, 0);
  endtask

  task automatic t_small_small();
    run_probe(0, 0, -1, 4'b0000, 24'h040000, 1'b0, 512, 512, 512, "small/small");
  endtask

  task automatic t_mid_big();
    run_probe(1, 2, -1, 4'b0110, 24'h280000, 1'b0, 257 + 258, 512, 256 + 258, "mid/big");
  endtask

  task automatic t_big_absent();
    run_probe(2, 3, -1, 4'b1000, 24'h200000, 1'b0, 258 + 3, 512, 256 + 3, "big/absent R6");
  endtask

  task automatic t_big_big();
    run_probe(2, 2, -1, 4'b1010, 24'h400000, 1'b0, 516, 512, 256 + 258, "big/big");
  endtask

  task automatic t_broken_word();
    run_probe(0, 0, 100, 4'b1010, 24'h0, 1'b1, 303, 256, 0, "broken R5");
  endtask

  task automatic t_bank0_absent();
    run_probe(3, 0, -1, 4'b1010, 24'h0, 1'b1, 3, 256, 0, "bank0 absent R5");
  endtask

  task automatic t_busy_and_idle();
    clear_mem(0, 0, -1);
    pulse_start();
    repeat (50) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 4'h5;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_q == 4'hA, "R10 write ignored while busy", cfg_q, 4'hA);
    pulse_start();
    wait_done();
    chk(n_wr == 512 && n_rd == 512, "R11 no restart", n_wr + n_rd, 1024);
    chk(cfg_q == 4'h0, "R10 busy write lost", cfg_q, 0);
    repeat (20) @(negedge clk);
    chk(done && !error && !mem_req, "R8 done held", {done, error, mem_req}, 3'b100);
    cfg_we = 1'b1; cfg_wdata = 4'h6;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_q == 4'h6, "R10 idle write", cfg_q, 6);
    cfg_we = 1'b1; cfg_wdata = 4'h3;
    pulse_start();
    cfg_we = 1'b0;
    chk(!done && cfg_q == 4'hA && mem_req, "R10 start wins, R8 done clears", {done, cfg_q}, 5'h0A);
    chk(!error, "R8 error only with done", error, 0);
    wait_done();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_small_small();
    t_mid_big();
    t_big_absent();
    t_big_big();
    t_broken_word();
    t_bank0_absent();
    t_busy_and_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule